// File: doc/BRIEF.md
# Way-Partitioned Victim Selector

This block chooses the way to replace when a lookup in a set-associative cache misses. Each processor core has its own eviction mask, and all hardware accelerator requesters share one further mask. In a mask, a 0 bit lets the requester replace that way and a 1 bit forbids it. The masks affect replacement only. A hit is reported by the tag compare logic outside this block, and any requester may hit in any way whatever its mask says.

On each lookup the block receives the requester identity, the hit result and the valid, dirty, lock and use bits of every way in the addressed set. One clock later it reports one of two results: a victim way, or a flag saying that no way may be replaced. With a victim it also reports whether a writeback is needed and which use bits the tag array must clear. A lock request fails when taking the chosen victim would leave the requester with no unlocked way it is allowed to replace. A small register port reads and writes the masks. A write with every mask bit set is rejected.

Top module: `way_victim_sel`

## Requirements
- R1: The mask in force is the shared hardware mask when `req_hw` is 1, and the mask of core `req_core` otherwise. A way is a candidate only if its mask bit is 0 and its lock bit is 0. A way that every mask forbids is never reported as a victim.
- R2: A way whose `tag_lock` bit is 1 is never reported as a victim.
- R3: Among the candidates, the block picks the lowest-numbered invalid way if one exists. Otherwise it picks the lowest-numbered way with its use bit clear. If every candidate has its use bit set, it picks the lowest-numbered candidate and drives `use_clr` with the full candidate set. In every other case `use_clr` is 0.
- R4: `vic_wb` is 1 exactly when the chosen victim has both its valid and dirty bits set.
- R5: A miss with no candidate sets `no_vic` to 1, and `vic_vld`, `vic_way`, `vic_wb` and `use_clr` to 0.
- R6: A lookup with `lk_hit` at 1 produces no victim and no `no_vic`, whatever the mask is.
- R7: A register write whose data has all WAYS bits set is ignored: the mask keeps its previous value. `cfg_err` is 1 for exactly the one cycle after that write.
- R8: `lock_fail` is 1 after a miss with `lock_req` at 1 when the number of candidates is 0 or 1.
- R9: After reset every mask is 0 and every lookup output is 0.
- R10: Lookup results appear on the cycle after the lookup is presented. A lookup uses the mask value from before any register write made in the same cycle.
- R11: `cfg_sel` values 0 to CORES-1 select the core masks, and the value CORES selects the hardware mask. `cfg_rdata` shows the selected mask combinationally. Any larger `cfg_sel` reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mask register write strobe |
| cfg_sel | input | $clog2(CORES+1) | Mask select: cores first, then the hardware mask |
| cfg_wdata | input | WAYS | Mask write data (1 forbids eviction) |
| cfg_rdata | output | WAYS | Selected mask, combinational read |
| cfg_err | output | 1 | One-cycle pulse after a rejected all-ones write |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_hit | input | 1 | Lookup hit |
| req_hw | input | 1 | Requester is a hardware accelerator |
| req_core | input | $clog2(CORES) | Core number of the requester |
| lock_req | input | 1 | Requester wants to lock the filled line |
| tag_valid | input | WAYS | Valid bits of the set |
| tag_dirty | input | WAYS | Dirty bits of the set |
| tag_lock | input | WAYS | Lock bits of the set |
| tag_use | input | WAYS | Use bits of the set |
| vic_vld | output | 1 | A victim way is reported |
| vic_way | output | $clog2(WAYS) | Victim way number |
| vic_wb | output | 1 | Victim must be written back |
| no_vic | output | 1 | Miss with no replaceable way |
| lock_fail | output | 1 | Lock request refused |
| use_clr | output | WAYS | Use bits to clear after an all-used choice |

## Verification
A mask write and a lookup that reads that same mask can arrive in the same cycle, and the lookup must then use the old mask. The bench provokes this on purpose: it writes a new mask for a core and looks up for that core in one cycle, then looks up again in the next cycle. Its model applies the write only after it has predicted the lookup, so a design that forwards the new value fails the first comparison. The random phase also mixes writes to every select value, some with all bits set, into cycles that carry lookups, so rejected and accepted writes both meet concurrent lookups.

// File: rtl/way_victim_sel.sv
module way_victim_sel #(
  parameter int WAYS  = 8,
  parameter int CORES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(CORES+1)-1:0] cfg_sel,
  input  logic [WAYS-1:0]            cfg_wdata,
  output logic [WAYS-1:0]            cfg_rdata,
  output logic                       cfg_err,
  input  logic                       lk_valid,
  input  logic                       lk_hit,
  input  logic                       req_hw,
  input  logic [$clog2(CORES)-1:0]   req_core,
  input  logic                       lock_req,
  input  logic [WAYS-1:0]            tag_valid,
  input  logic [WAYS-1:0]            tag_dirty,
  input  logic [WAYS-1:0]            tag_lock,
  input  logic [WAYS-1:0]            tag_use,
  output logic                       vic_vld,
  output logic [$clog2(WAYS)-1:0]    vic_way,
  output logic                       vic_wb,
  output logic                       no_vic,
  output logic                       lock_fail,
  output logic [WAYS-1:0]            use_clr
);
  localparam int SW = $clog2(CORES+1);
  localparam int CW = $clog2(CORES);
  localparam int WW = $clog2(WAYS);
  localparam logic [SW-1:0] HW_SEL = SW'(CORES);

  logic [WAYS-1:0] core_mask [CORES];
  logic [WAYS-1:0] hw_mask;
  logic [WAYS-1:0] cur_mask, cand, inv, fresh;
  logic [WW-1:0]   pick;
  logic            miss, all_used;

  function automatic logic [WW-1:0] lowest(input logic [WAYS-1:0] v);
    lowest = '0;
    for (int i = WAYS-1; i >= 0; i--)
      if (v[i]) lowest = WW'(i);
  endfunction

  wire bad_wr = cfg_we && (&cfg_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < CORES; c++) core_mask[c] <= '0;
      hw_mask <= '0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= bad_wr;
      if (cfg_we && !bad_wr) begin
        if (cfg_sel < HW_SEL) core_mask[cfg_sel[CW-1:0]] <= cfg_wdata;
        else if (cfg_sel == HW_SEL) hw_mask <= cfg_wdata;
      end
    end
  end

  always_comb begin
    if (cfg_sel < HW_SEL)       cfg_rdata = core_mask[cfg_sel[CW-1:0]];
    else if (cfg_sel == HW_SEL) cfg_rdata = hw_mask;
    else                        cfg_rdata = '0;
  end

  assign cur_mask = req_hw ? hw_mask : core_mask[req_core];
  assign cand     = ~cur_mask & ~tag_lock;
  assign inv      = cand & ~tag_valid;
  assign fresh    = cand & ~tag_use;
  assign all_used = (|cand) && !(|inv) && !(|fresh);
  assign pick     = (|inv) ? lowest(inv) : (|fresh) ? lowest(fresh) : lowest(cand);
  assign miss     = lk_valid && !lk_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_vld <= 1'b0; vic_way <= '0; vic_wb <= 1'b0;
      no_vic <= 1'b0; lock_fail <= 1'b0; use_clr <= '0;
    end else begin
      vic_vld   <= miss && (|cand);
      vic_way   <= (miss && (|cand)) ? pick : '0;
      vic_wb    <= miss && (|cand) && tag_valid[pick] && tag_dirty[pick];
      no_vic    <= miss && !(|cand);
      lock_fail <= miss && lock_req && !(|(cand & (cand - WAYS'(1))));
      use_clr   <= (miss && all_used) ? cand : '0;
    end
  end

  // R1 R2
  vic_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_vld |-> ((($past(cur_mask | tag_lock) >> vic_way) & WAYS'(1)) == '0));
  // R5
  vic_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vic_vld, no_vic}));
  // R4
  wb_needs_vic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_wb |-> vic_vld);
  // R3
  use_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|use_clr) |-> (vic_vld && use_clr[vic_way]));
  // R6
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_hit) |=> (!vic_vld && !no_vic));
  // R7
  bad_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (&cfg_wdata)) |=> cfg_err);
  // R8
  lock_fail_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fail |-> $past(lock_req && lk_valid && !lk_hit));
endmodule

// File: tb/way_victim_sel_bench.sv
`timescale 1ns/1ps
module way_victim_sel_bench;
  localparam int WAYS = 8, CORES = 4;
  logic clk = 0, rst_n;
  logic cfg_we; logic [2:0] cfg_sel; logic [7:0] cfg_wdata, cfg_rdata; logic cfg_err;
  logic lk_valid, lk_hit, req_hw, lock_req; logic [1:0] req_core;
  logic [7:0] tag_valid, tag_dirty, tag_lock, tag_use, use_clr;
  logic vic_vld, vic_wb, no_vic, lock_fail; logic [2:0] vic_way;
  int n_chk = 0, n_bad = 0;
  logic [7:0] m_core [4]; logic [7:0] m_hw;

  way_victim_sel #(.WAYS(WAYS), .CORES(CORES)) u_way_victim_sel (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  function automatic logic [7:0] mread(input logic [2:0] s);
    if (s < 4) return m_core[s[1:0]];
    if (s == 4) return m_hw;
    return 8'h00;
  endfunction

  task automatic step(input bit we, input logic [2:0] sel, input logic [7:0] wd,
                      input bit lv, input bit hit, input bit hw, input logic [1:0] core,
                      input bit lr, input logic [7:0] tv, input logic [7:0] td,
                      input logic [7:0] tl, input logic [7:0] tu);
    logic [7:0] mk, cd, e_clr; int e_way, ncd; bit e_vld, e_no, e_wb, e_lf, e_err, found;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd; lk_valid = lv; lk_hit = hit;
    req_hw = hw; req_core = core; lock_req = lr;
    tag_valid = tv; tag_dirty = td; tag_lock = tl; tag_use = tu;
    mk = hw ? m_hw : m_core[core];
    ncd = 0; e_way = 0; found = 0; e_clr = 0;
    for (int i = 0; i < 8; i++) begin cd[i] = !mk[i] && !tl[i]; ncd += cd[i]; end
    for (int i = 0; i < 8; i++) if (!found && cd[i] && !tv[i]) begin e_way = i; found = 1; end
    for (int i = 0; i < 8; i++) if (!found && cd[i] && !tu[i]) begin e_way = i; found = 1; end
    for (int i = 0; i < 8; i++) if (!found && cd[i]) begin e_way = i; found = 1; e_clr = cd; end
    e_vld = lv && !hit && ncd > 0;
    e_no  = lv && !hit && ncd == 0;
    e_lf  = lv && !hit && lr && ncd <= 1;
    if (!e_vld) begin e_way = 0; e_clr = 0; end
    e_wb  = e_vld && tv[e_way] && td[e_way];
    e_err = we && wd == 8'hFF;
    if (we && wd != 8'hFF) begin
      if (sel < 4) m_core[sel[1:0]] = wd; else if (sel == 4) m_hw = wd;
    end
    @(negedge clk);
    check(vic_vld == e_vld, "R1 R5 R6 R10 vic_vld", vic_vld, e_vld);
    check(vic_way == e_way, "R1 R2 R3 vic_way", vic_way, e_way);
    check(use_clr == e_clr, "R3 use_clr", use_clr, e_clr);
    check(vic_wb == e_wb, "R4 vic_wb", vic_wb, e_wb);
    check(no_vic == e_no, "R5 no_vic", no_vic, e_no);
    check(lock_fail == e_lf, "R8 lock_fail", lock_fail, e_lf);
    check(cfg_err == e_err, "R7 cfg_err", cfg_err, e_err);
    check(cfg_rdata == mread(sel), "R7 R11 cfg_rdata", cfg_rdata, mread(sel));
    cfg_we = 0; lk_valid = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < 4; c++) m_core[c] = 0;
    m_hw = 0;
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; lk_valid = 0; lk_hit = 0;
    req_hw = 0; req_core = 0; lock_req = 0;
    tag_valid = 0; tag_dirty = 0; tag_lock = 0; tag_use = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!vic_vld && !no_vic && !vic_wb && !lock_fail && use_clr == 0 && !cfg_err,
          "R9 outputs", {vic_vld, no_vic, vic_wb, lock_fail}, 0);
    check(cfg_rdata == 0, "R9 mask", cfg_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    // R1 core mask forbids upper ways
    step(1, 0, 8'hF0, 0, 0, 0, 0, 0, 8'hFF, 8'h00, 8'h00, 8'h00);
    step(0, 0, 0, 1, 0, 0, 0, 0, 8'hFF, 8'h00, 8'h00, 8'h00);
    // R7 all-ones rejected
    step(1, 0, 8'hFF, 0, 0, 0, 0, 0, 8'hFF, 8'h00, 8'h00, 8'h00);
    // R1 hw mask
    step(1, 4, 8'h0F, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 4, 0, 1, 0, 1, 0, 0, 8'hFF, 8'h00, 8'h00, 8'h00);
    // R2 R8 one candidate left
    step(0, 4, 0, 1, 0, 1, 0, 1, 8'hFF, 8'h00, 8'h70, 8'h00);
    // R3 all use set, clear
    step(0, 0, 0, 1, 0, 0, 0, 0, 8'hFF, 8'h00, 8'h00, 8'hFF);
    // R3 invalid preferred; R4 dirty
    step(0, 0, 0, 1, 0, 0, 0, 0, 8'hF7, 8'h00, 8'h00, 8'h00);
    step(0, 0, 0, 1, 0, 0, 0, 0, 8'hFF, 8'h04, 8'h00, 8'h03);
    // R5 all locked
    step(0, 0, 0, 1, 0, 0, 0, 1, 8'hFF, 8'h00, 8'hFF, 8'h00);
    // R6 hit while blocked
    step(1, 1, 8'hFE, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 1, 1, 0, 1, 0, 8'hFF, 8'hFF, 8'hFF, 8'h00);
    // R10 write and lookup same cycle: old mask used
    step(1, 2, 8'h0F, 1, 0, 0, 2, 0, 8'hFF, 8'h00, 8'h00, 8'h00);
    step(0, 2, 0, 1, 0, 0, 2, 0, 8'hFF, 8'h00, 8'h00, 8'h00);
    // R11 out-of-range select
    step(1, 7, 8'h55, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] wd;
      wd = ($urandom % 8 == 0) ? 8'hFF : 8'($urandom);
      step($urandom % 4 == 0, 3'($urandom % 6), wd, $urandom % 8 != 0, $urandom % 5 == 0,
           $urandom % 3 == 0, 2'($urandom), $urandom % 4 == 0,
           8'($urandom | $urandom), 8'($urandom), 8'($urandom & $urandom & $urandom),
           8'($urandom | $urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule